// File: doc/BRIEF.md
# PHY Link Interrupt Register Block

This block is the interrupt part of a single-link Ethernet PHY's management registers. A one-bit link indication comes in from the link-detection logic. It passes through a synchronizer and then into a two-state link tracker. Each time the tracked level flips, the block latches a link-change event and a sticky summary flag. Software reaches three registers over a simple word bus, which has an address, write data, write strobe, read strobe and registered read data.

The interrupt output is asserted when three conditions hold together: the global interrupt enable is set, the output driver enable is set, and the link-change event is both enabled and pending. Software chooses the active level. When the driver enable is clear, the block releases the pad by dropping its output-enable line, so the pad floats. A read of the status register clears the summary flag, but this does not release the pin. The pin is released only when the event itself is cleared, by reading the interrupt register.

The link tracker has two states. In `LNK_DOWN` it moves to `LNK_UP` when the synchronized input reads 1. In `LNK_UP` it moves to `LNK_DOWN` when the synchronized input reads 0. Each of these two transitions produces a one-cycle change strobe. In all other cases the tracker stays in its current state and no strobe is produced.

Top module: `phy_irq_regs`

## Requirements
- R1: After reset every register reads zero, the tracker is in `LNK_DOWN`, `irq_oe` is 0 and `rd_data` is 0.
- R2: A change on `link_in` reaches status bit 0 (address 0x10) SYNC_STAGES+1 clock edges after it is sampled. With the interrupt fully enabled, the pin becomes active at that same edge and not one edge earlier.
- R3: A link change in either direction sets event bit 13 of the interrupt register (0x12) and summary bit 7 of the status register (0x10).
- R4: A read of 0x10 returns summary bit 7 as it was before the read, then clears it. Event bit 13 is not changed by this read, and the pin stays active.
- R5: A read of 0x12 returns event bit 13 as it was before the read, then clears it.
- R6: At 0x11, only bits 3 (polarity), 1 (interrupt enable) and 0 (driver enable) are writable. At 0x12, only bit 5 (link-event enable) is writable. All other bits read zero. Writes to 0x10 and writes to bit 13 have no effect.
- R7: The interrupt is active when bit 1 of 0x11 and bit 0 of 0x11 are set and bits 5 and 13 of 0x12 are both set. When bit 3 of 0x11 is 1, `irq_o` equals the active state. When bit 3 is 0, `irq_o` is the inverse of the active state.
- R8: `irq_oe` equals bit 0 of 0x11. When it is 0, the pad is released.
- R9: When a link change and a read of 0x12 fall on the same edge, the event stays set.
- R10: Reads at any address other than 0x10, 0x11 and 0x12 return zero.
- R11: `rd_data` carries the addressed value in the cycle after `rd_en`. In every other cycle it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_in | input | 1 | Asynchronous link level |
| addr | input | ADDR_W | Register address |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt pad level |
| irq_oe | output | 1 | Interrupt pad driver enable |

## Verification
The bench builds the block with its default parameters: SYNC_STAGES=2 and ADDR_W=8. With two synchronizer stages the pin latency is three edges, so the bench can check exactly when the pin turns on. With an 8-bit address, unmapped locations are cheap to probe.

The pin logic has four configuration bits and one event bit, 32 combinations in all. The bench sweeps every one of them and computes the expected pin level and driver enable arithmetically from those bits.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
    localparam int DATA_W      = 16;
    localparam int ADR_STAT    = 'h10;
    localparam int ADR_CFG     = 'h11;
    localparam int ADR_INT     = 'h12;
    localparam int B_LINK      = 0;
    localparam int B_SUMMARY   = 7;
    localparam int B_POL       = 3;
    localparam int B_IEN       = 1;
    localparam int B_OE        = 0;
    localparam int B_LNK_EN    = 5;
    localparam int B_LNK_EVT   = 13;

    typedef enum logic {
        LNK_DOWN = 1'b0,
        LNK_UP   = 1'b1
    } link_state_e;
endpackage

// File: rtl/phy_irq_link_fsm.sv
module phy_irq_link_fsm
    import phy_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_async,
    output logic link_up,
    output logic link_chg
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   link_s;
    link_state_e            state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], link_async};
    end

    assign link_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LNK_DOWN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        link_chg = 1'b0;
        unique case (state_q)
            LNK_DOWN: if (link_s) begin
                state_d  = LNK_UP;
                link_chg = 1'b1;
            end
            LNK_UP: if (!link_s) begin
                state_d  = LNK_DOWN;
                link_chg = 1'b1;
            end
        endcase
    end

    assign link_up = (state_q == LNK_UP);
endmodule

// File: rtl/phy_irq_pin.sv
module phy_irq_pin (
    input  logic irq_en,
    input  logic drv_en,
    input  logic act_high,
    input  logic pending,
    output logic irq_o,
    output logic irq_oe
);
    logic active;

    always_comb begin
        active = irq_en & drv_en & pending;
        irq_o  = act_high ? active : ~active;
        irq_oe = drv_en;
    end
endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
    import phy_irq_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [15:0]       rd_data,
    output logic              irq_o,
    output logic              irq_oe
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADR_CFG);
    localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(ADR_INT);

    logic link_up, link_chg;
    logic cfg_pol, cfg_ien, cfg_oe, lnk_en;
    logic evt_lnk, sum_flag;
    logic [DATA_W-1:0] rd_mux;

    phy_irq_link_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_link (
        .clk(clk), .rst_n(rst_n), .link_async(link_in),
        .link_up(link_up), .link_chg(link_chg)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_pol <= 1'b0;
            cfg_ien <= 1'b0;
            cfg_oe  <= 1'b0;
            lnk_en  <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_CFG) begin
                cfg_pol <= wr_data[B_POL];
                cfg_ien <= wr_data[B_IEN];
                cfg_oe  <= wr_data[B_OE];
            end
            if (addr == A_INT) lnk_en <= wr_data[B_LNK_EN];
        end
    end

    // a new change outranks a clearing read on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_lnk  <= 1'b0;
            sum_flag <= 1'b0;
        end else begin
            if (link_chg)                       evt_lnk <= 1'b1;
            else if (rd_en && addr == A_INT)    evt_lnk <= 1'b0;
            if (link_chg)                       sum_flag <= 1'b1;
            else if (rd_en && addr == A_STAT)   sum_flag <= 1'b0;
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (1'b1)
            addr == A_STAT: begin
                rd_mux[B_LINK]    = link_up;
                rd_mux[B_SUMMARY] = sum_flag;
            end
            addr == A_CFG: begin
                rd_mux[B_POL] = cfg_pol;
                rd_mux[B_IEN] = cfg_ien;
                rd_mux[B_OE]  = cfg_oe;
            end
            addr == A_INT: begin
                rd_mux[B_LNK_EN]  = lnk_en;
                rd_mux[B_LNK_EVT] = evt_lnk;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
        else            rd_data <= '0;
    end

    phy_irq_pin u_pin (
        .irq_en(cfg_ien), .drv_en(cfg_oe), .act_high(cfg_pol),
        .pending(lnk_en & evt_lnk), .irq_o(irq_o), .irq_oe(irq_oe)
    );
endmodule

// File: rtl/phy_irq_chk.sv
module phy_irq_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       wr_data,
    input logic              wr_en,
    input logic              rd_en,
    input logic [15:0]       rd_data,
    input logic              irq_oe,
    input logic              link_up,
    input logic              link_chg,
    input logic              evt_lnk,
    input logic              sum_flag
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h10);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'('h11);
    localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'('h12);

    AST_LINK_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        link_chg |=> (link_up != $past(link_up))); // R2
    AST_EVENT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        link_chg |=> (evt_lnk && sum_flag)); // R3
    AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_STAT && !link_chg) |=> !sum_flag); // R4
    AST_INT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_INT && !link_chg) |=> !evt_lnk); // R5
    AST_OE_FROM_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CFG) |=> (irq_oe == $past(wr_data[0]))); // R8
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == 16'h0)); // R11
endmodule

bind phy_irq_regs phy_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .irq_oe(irq_oe),
    .link_up(link_up), .link_chg(link_chg), .evt_lnk(evt_lnk),
    .sum_flag(sum_flag)
);

// File: tb/phy_irq_regs_test.sv
module phy_irq_regs_test;
    localparam int ADDR_W = 8;
    localparam int SYNC   = 2;

    logic clk = 1'b0, rst_n = 1'b0, link_in = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0] wr_data = '0, rd_data, rv;
    logic wr_en = 1'b0, rd_en = 1'b0, irq_o, irq_oe;
    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    phy_irq_regs #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .link_in(link_in), .addr(addr),
        .wr_data(wr_data), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
        .irq_o(irq_o), .irq_oe(irq_oe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        addr = ADDR_W'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        addr = ADDR_W'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (SYNC + 2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq_oe", {15'h0, irq_oe}, 16'h0);
        check("R1 rd_data", rd_data, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd('h10, rv); check("R1 status", rv, 16'h0);
        rd('h11, rv); check("R1 cfg", rv, 16'h0);
        rd('h12, rv); check("R1 int", rv, 16'h0);
        @(negedge clk);
        check("R11 idle rd_data", rd_data, 16'h0);

        // R6 writable masks, R10 unmapped
        wr('h11, 16'hFFFF); rd('h11, rv); check("R6 cfg mask", rv, 16'h000B);
        wr('h12, 16'hFFFF); rd('h12, rv); check("R6 int mask", rv, 16'h0020);
        wr('h10, 16'hFFFF); rd('h10, rv); check("R6 status ro", rv, 16'h0000);
        rd('h13, rv); check("R10 0x13", rv, 16'h0);
        rd('h00, rv); check("R10 0x00", rv, 16'h0);
        rd('hFF, rv); check("R10 0xFF", rv, 16'h0);

        // R2 latency, active high, fully enabled (cfg=0xB, lnk_en=1)
        link_in = 1'b1;
        repeat (SYNC) @(negedge clk);
        check("R2 pin not yet", {15'h0, irq_o}, 16'h0);
        @(negedge clk);
        check("R2 pin at edge", {15'h0, irq_o}, 16'h1);
        rd('h10, rv); check("R3 R4 status rise", rv, 16'h0081);
        check("R4 pin held after status read", {15'h0, irq_o}, 16'h1);
        rd('h10, rv); check("R4 summary cleared", rv, 16'h0001);
        rd('h12, rv); check("R3 R5 event rise", rv, 16'h2020);
        check("R5 pin released", {15'h0, irq_o}, 16'h0);
        rd('h12, rv); check("R5 event cleared", rv, 16'h0020);

        // R3 falling change
        link_in = 1'b0; settle();
        rd('h12, rv); check("R3 event fall", rv, 16'h2020);
        rd('h10, rv); check("R3 status fall", rv, 16'h0080);

        // R9 change and clearing read on the same edge
        link_in = 1'b1;
        @(negedge clk); @(negedge clk);
        rd('h12, rv); check("R9 pre-change read", rv, 16'h0020);
        rd('h12, rv); check("R9 event kept", rv, 16'h2020);
        rd('h10, rv);

        // R7 R8 sweep of config bits and event state
        for (int e = 0; e < 2; e++) begin
            if (e == 1) begin
                link_in = ~link_in; settle();
            end else begin
                rd('h12, rv);
            end
            for (int c = 0; c < 16; c++) begin
                logic oe, ien, pol, len, act;
                oe = c[0]; ien = c[1]; pol = c[2]; len = c[3];
                wr('h11, {12'h0, pol, 1'b0, ien, oe});
                wr('h12, {10'h0, len, 5'h0});
                act = oe & ien & len & (e == 1);
                check("R8 oe", {15'h0, irq_oe}, {15'h0, oe});
                if (oe) check("R7 level", {15'h0, irq_o}, {15'h0, pol ? act : ~act});
            end
        end
        rd('h12, rv); check("R5 sweep event", rv, 16'h2020);
        @(negedge clk);
        check("R11 idle after read", rd_data, 16'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule